// File: doc/BRIEF.md
# Paired Reference Frame Synchronizer

This block takes eight reference lines arranged as four pairs, where lines 0 to 3 carry bit clocks and lines 4 to 7 carry the matching frame strobes. A 4-bit select field and an enable bit in a control word choose one pair. Each signal of the pair can be inverted on its own. The frame strobe is sampled on the active bit-clock edge, and the chosen frame transition becomes a one-cycle frame event in the system clock domain. That event is the point where the internal timing locks to the frame. The selected bit clock is also divided by a programmable factor, and the result is the reference for a downstream phase-locked loop.

All reference lines are asynchronous to the system clock. The block brings both lines of the chosen pair through two-flop synchronizers and then does all edge work on system-clock samples. A small state machine tracks lock to the frame and raises a flag when frames stop arriving.

The state machine has four states: `ST_IDLE`, `ST_HUNT`, `ST_LOCKED` and `ST_LOST`. It moves between them on these transitions:
- `ST_IDLE` to `ST_HUNT` when pairing becomes active.
- `ST_HUNT` to `ST_LOCKED` on the first frame event.
- `ST_LOCKED` to `ST_LOST` when the gap counter reaches the limit.
- `ST_LOST` to `ST_LOCKED` on the next frame event.
- Any other state to `ST_IDLE` as soon as pairing becomes inactive.

Top module: `paired_frame_sync`

## Requirements
- R1: Pairing is active only when control bit 4 is 1 and the select field is binary 1000 to 1011. While it is inactive, `frame_evt` stays 0 and `div_clk` stays 0.
- R2: Select value 1000+k uses `ref_in[k]` as the bit clock and `ref_in[k+4]` as the frame strobe. The other six lines have no effect.
- R3: Control bit 2 inverts the bit clock, so the frame strobe is sampled on the falling edge of the raw bit clock. With a frame that changes mid-high, the event comes 4 system cycles earlier than without inversion, using a bit clock of 8 system cycles.
- R4: Control bit 3 inverts the frame strobe, so the event follows the falling frame transition instead of the rising one.
- R5: `frame_evt` is one system cycle wide. There is exactly one event per frame period.
- R6: An 8 kHz frame with an 8.192 MHz bit clock gives one event every 1024 bit-clock periods.
- R7: With divider value N, the period of `div_clk` is N+1 bit-clock periods. For N=0, `div_clk` follows the synchronized bit clock.
- R8: `frame_lost` rises once 1100 active bit-clock edges pass with no frame event. It clears on the next event.
- R9: After reset, `frame_evt`, `div_clk` and `frame_lost` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ref_in | input | 8 | Bit clocks [3:0], frame strobes [7:4] |
| ctrl | input | 8 | Bit 4 enable, bit 3 frame invert, bit 2 bit-clock invert |
| clk_sel | input | 4 | Pair select, 1000+k picks pair k |
| div_val | input | 8 | Divider value N, divide by N+1 |
| frame_evt | output | 1 | One-cycle frame event |
| div_clk | output | 1 | Divided bit clock for the downstream loop |
| frame_lost | output | 1 | No frame within the gap limit |

## Verification
The bench sweeps all four pairs against all four inversion settings. The unselected lines carry decoy clocks and frames with other periods, so a wrong pick shows up as a wrong event interval.

Event phases are compared across the sweep:
- Equal phases on every pair confirm that selection and synchronization are uniform.
- A shift by the strobe width separates rising-frame from falling-frame sync.
- A 4-cycle advance separates rising-edge from falling-edge sampling.

The divider is tried with N of 0, 1, 3 and 6, which covers pass-through, even and odd factors. The bench also runs the full-rate 1024-bit frame, three inactive settings, and a frame outage whose flag is checked just before and just after the 1100-edge limit.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2,
        ST_LOST   = 2'd3
    } sync_state_t;

    localparam int CTRL_INV_BCLK_BIT = 2;
    localparam int CTRL_INV_FRM_BIT  = 3;
    localparam int CTRL_EN_BIT       = 4;
    localparam logic [1:0] SEL_PAIR_PREFIX = 2'b10;
endpackage

// File: rtl/ref_pair_select.sv
module ref_pair_select #(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int PICK_W     = $clog2(NUM_PAIRS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  logic [2*NUM_PAIRS-1:0] ref_in,
    input  logic [PICK_W-1:0]      pick,
    input  logic                   inv_bclk,
    input  logic                   inv_frm,
    output logic                   bclk_lvl,
    output logic                   bclk_edge,
    output logic                   frm_lvl
);
    logic [NUM_PAIRS-1:0]   bclk_lines;
    logic [NUM_PAIRS-1:0]   frm_lines;
    logic                   bclk_raw;
    logic                   frm_raw;
    logic [SYNC_STAGES-1:0] bclk_sh;
    logic [SYNC_STAGES-1:0] frm_sh;
    logic                   bclk_prev;

    assign bclk_lines = ref_in[NUM_PAIRS-1:0];
    assign frm_lines  = ref_in[2*NUM_PAIRS-1:NUM_PAIRS];
    assign bclk_raw   = bclk_lines[pick] ^ inv_bclk;
    assign frm_raw    = frm_lines[pick] ^ inv_frm;

    // Synchronizer chains into the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_sh   <= '0;
            frm_sh    <= '0;
            bclk_prev <= 1'b0;
        end else begin
            bclk_sh   <= {bclk_sh[SYNC_STAGES-2:0], bclk_raw};
            frm_sh    <= {frm_sh[SYNC_STAGES-2:0], frm_raw};
            bclk_prev <= bclk_sh[SYNC_STAGES-1];
        end
    end

    assign bclk_lvl  = active & bclk_sh[SYNC_STAGES-1];
    assign bclk_edge = active & bclk_sh[SYNC_STAGES-1] & ~bclk_prev;
    assign frm_lvl   = frm_sh[SYNC_STAGES-1];

    // R5: a synchronized bit-clock edge never lasts two cycles
    a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_edge |=> !bclk_edge);
endmodule

// File: rtl/frame_edge_det.sv
module frame_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bclk_edge,
    input  logic frm_lvl,
    output logic frame_evt
);
    logic frm_cap;

    // Capture the strobe on each active bit-clock edge; fire on a low-to-high capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_cap   <= 1'b1;
            frame_evt <= 1'b0;
        end else if (!active) begin
            frm_cap   <= 1'b1;
            frame_evt <= 1'b0;
        end else begin
            frame_evt <= 1'b0;
            if (bclk_edge) begin
                frm_cap   <= frm_lvl;
                frame_evt <= frm_lvl & ~frm_cap;
            end
        end
    end

    // R5: an event only follows a bit-clock sampling edge
    a_r5_evt_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |-> $past(bclk_edge));
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             bclk_edge,
    input  logic             bclk_lvl,
    input  logic [DIV_W-1:0] div_val,
    output logic             div_clk
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W:0]   half;
    logic             div_q;

    assign half    = ({1'b0, div_val} + 1'b1) >> 1;
    assign cnt_nxt = (cnt >= div_val) ? '0 : cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (!active) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (bclk_edge) begin
            cnt   <= cnt_nxt;
            div_q <= ({1'b0, cnt_nxt} < half);
        end
    end

    assign div_clk = active & ((div_val == '0) ? bclk_lvl : div_q);

    // R7: the edge counter stays within the programmed range
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bclk_edge) |=> (cnt <= $past(div_val)));
endmodule

// File: rtl/pair_sync_fsm.sv
module pair_sync_fsm
    import pfs_pkg::*;
#(
    parameter int LOST_LIMIT = 1100,
    localparam int GAP_W     = $clog2(LOST_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bclk_edge,
    input  logic frame_evt,
    output logic frame_lost
);
    sync_state_t state;
    sync_state_t state_nxt;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_full;

    assign gap_full = (gap_cnt == GAP_W'(LOST_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (active) state_nxt = ST_HUNT;
            ST_HUNT:   if (!active) state_nxt = ST_IDLE;
                       else if (frame_evt) state_nxt = ST_LOCKED;
            ST_LOCKED: if (!active) state_nxt = ST_IDLE;
                       else if (gap_full) state_nxt = ST_LOST;
            ST_LOST:   if (!active) state_nxt = ST_IDLE;
                       else if (frame_evt) state_nxt = ST_LOCKED;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Bit-clock edges since the last frame event, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     gap_cnt <= '0;
        else if (!active || frame_evt)  gap_cnt <= '0;
        else if (bclk_edge && !gap_full) gap_cnt <= gap_cnt + 1'b1;
    end

    always_comb begin
        frame_lost = (state == ST_LOST);
    end

    // R8: the flag only rises after the gap reached its limit
    a_r8_lost_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lost) |-> $past(gap_full));
    // R8: the flag never stays up through inactive operation
    a_r8_lost_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(!active)) |-> !frame_lost);
endmodule

// File: rtl/paired_frame_sync.sv
module paired_frame_sync
    import pfs_pkg::*;
#(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 8,
    parameter int LOST_LIMIT  = 1100,
    localparam int PICK_W     = $clog2(NUM_PAIRS),
    localparam int SEL_W      = PICK_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_PAIRS-1:0] ref_in,
    input  logic [7:0]             ctrl,
    input  logic [SEL_W-1:0]       clk_sel,
    input  logic [DIV_W-1:0]       div_val,
    output logic                   frame_evt,
    output logic                   div_clk,
    output logic                   frame_lost
);
    logic active;
    logic bclk_lvl;
    logic bclk_edge;
    logic frm_lvl;

    assign active = ctrl[CTRL_EN_BIT] && (clk_sel[SEL_W-1 -: 2] == SEL_PAIR_PREFIX);

    ref_pair_select #(.NUM_PAIRS(NUM_PAIRS), .SYNC_STAGES(SYNC_STAGES)) u_sel (
        .clk(clk), .rst_n(rst_n), .active(active), .ref_in(ref_in),
        .pick(clk_sel[PICK_W-1:0]),
        .inv_bclk(ctrl[CTRL_INV_BCLK_BIT]), .inv_frm(ctrl[CTRL_INV_FRM_BIT]),
        .bclk_lvl(bclk_lvl), .bclk_edge(bclk_edge), .frm_lvl(frm_lvl)
    );

    frame_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .active(active), .bclk_edge(bclk_edge),
        .frm_lvl(frm_lvl), .frame_evt(frame_evt)
    );

    ref_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .active(active), .bclk_edge(bclk_edge),
        .bclk_lvl(bclk_lvl), .div_val(div_val), .div_clk(div_clk)
    );

    pair_sync_fsm #(.LOST_LIMIT(LOST_LIMIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .bclk_edge(bclk_edge),
        .frame_evt(frame_evt), .frame_lost(frame_lost)
    );

    // R1: a settled inactive configuration is quiet at both outputs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(!active)) |-> (!frame_evt && !div_clk));
    // R5: frame events are single-cycle pulses
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |=> !frame_evt);
endmodule

// File: tb/paired_frame_sync_test.sv
module paired_frame_sync_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ref_in = '0;
    logic [7:0] ctrl = '0;
    logic [3:0] clk_sel = '0;
    logic [7:0] div_val = 8'd3;
    logic       frame_evt, div_clk, frame_lost;

    int n_chk = 0, n_bad = 0;
    int gcnt = 1000;
    int P = 128, FW = 5, gk = 0;
    bit frm_on = 1'b1;
    int ev_cnt = 0, ev_t = 0, ev_int = 0;
    int dv_t = 0, dv_int = 0;
    bit div_q = 1'b0, div_hi_seen = 1'b0;
    int p_base [4];

    always #5 clk = ~clk;

    paired_frame_sync uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ctrl(ctrl), .clk_sel(clk_sel),
        .div_val(div_val), .frame_evt(frame_evt), .div_clk(div_clk), .frame_lost(frame_lost)
    );

    // Monitor and stimulus generator, all on the falling edge
    always @(negedge clk) begin
        if (frame_evt) begin
            ev_cnt++;
            ev_int = gcnt - ev_t;
            ev_t = gcnt;
        end
        if (div_clk && !div_q) begin
            dv_int = gcnt - dv_t;
            dv_t = gcnt;
        end
        div_q = div_clk;
        if (div_clk) div_hi_seen = 1'b1;
        gcnt++;
        for (int k = 0; k < 4; k++) begin
            if (k == gk) begin
                ref_in[k]   = ((gcnt % 8) < 4);
                ref_in[k+4] = frm_on && (((gcnt + P - 2) % P) < FW * 8);
            end else begin
                ref_in[k]   = ((gcnt % 6) < 3);
                ref_in[k+4] = (((gcnt + 37) % 104) < 16);
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic setup(bit en, bit invb, bit invf, int sel, int k);
        @(posedge clk); #2;
        ctrl = {3'b000, en, invf, invb, 2'b00};
        clk_sel = 4'(sel);
        gk = k;
    endtask

    initial begin
        int c0, ph, want;
        cycles(5);
        check("R9", int'(frame_evt), 0, "frame_evt after reset");
        check("R9", int'(div_clk), 0, "div_clk after reset");
        check("R9", int'(frame_lost), 0, "frame_lost after reset");
        rst_n = 1'b1;

        // R2 R3 R4 R5: all pairs under all inversion settings
        for (int inv = 0; inv < 4; inv++) begin
            for (int k = 0; k < 4; k++) begin
                setup(1'b1, inv[0], inv[1], 8 + k, k);
                cycles(3 * P);
                c0 = ev_cnt;
                cycles(4 * P);
                check("R5", ev_cnt - c0, 4, "events in four frames");
                check("R5", ev_int, P, "event interval");
                ph = ev_t % P;
                if (inv == 0) begin
                    p_base[k] = ph;
                    check("R2", ph, p_base[0], "phase equal across pairs");
                end else if (inv == 1) begin
                    check("R3", ph, (p_base[k] + P - 4) % P, "falling bit-edge sampling phase");
                end else if (inv == 2) begin
                    check("R4", ph, (p_base[k] + FW * 8) % P, "falling frame transition phase");
                end else begin
                    check("R4", ph, (p_base[k] + FW * 8 + P - 4) % P, "both inverted phase");
                end
            end
        end

        // R1: inactive settings
        for (int m = 0; m < 3; m++) begin
            if (m == 0) setup(1'b0, 1'b0, 1'b0, 8, 0);
            else if (m == 1) setup(1'b1, 1'b0, 1'b0, 7, 0);
            else setup(1'b1, 1'b0, 1'b0, 12, 0);
            cycles(3 * P);
            c0 = ev_cnt;
            div_hi_seen = 1'b0;
            cycles(4 * P);
            check("R1", ev_cnt - c0, 0, "events while inactive");
            check("R1", int'(div_hi_seen), 0, "div_clk high while inactive");
        end

        // R7: divider factors
        for (int d = 0; d < 4; d++) begin
            want = (d == 0) ? 0 : (d == 1) ? 1 : (d == 2) ? 3 : 6;
            setup(1'b1, 1'b0, 1'b0, 10, 2);
            div_val = 8'(want);
            cycles(40 * 8);
            check("R7", dv_int, (want + 1) * 8, "div_clk period");
        end
        div_val = 8'd3;

        // R8: frame outage
        setup(1'b1, 1'b0, 1'b0, 8, 0);
        cycles(3 * P);
        check("R8", int'(frame_lost), 0, "flag with frames present");
        c0 = ev_cnt;
        while (ev_cnt == c0) cycles(1);
        frm_on = 1'b0;
        while (gcnt < ev_t + 1090 * 8) cycles(1);
        check("R8", int'(frame_lost), 0, "flag before limit");
        while (gcnt < ev_t + 1110 * 8) cycles(1);
        check("R8", int'(frame_lost), 1, "flag after limit");
        frm_on = 1'b1;
        cycles(2 * P);
        check("R8", int'(frame_lost), 0, "flag after frames resume");

        // R6: 1024 bit clocks per frame
        setup(1'b1, 1'b0, 1'b0, 8, 0);
        P = 8192;
        FW = 1;
        cycles(2 * P);
        c0 = ev_cnt;
        cycles(2 * P);
        check("R6", ev_cnt - c0, 2, "events in two long frames");
        check("R6", ev_int, 8192, "long frame interval");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(1500000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule